// File: doc/BRIEF.md
# Multi-Block Erase Scheduler

This block sequences erase work for a seven-block flash array. A command decoder feeds it block-erase confirms, each carrying an address, and chip-erase requests. A block confirm opens a collection window. Every further confirm adds its block and starts the window again, so several blocks pile up into one erase job. When the window expires, protected blocks are dropped from the job. The blocks that remain are then handed to an array model one at a time through a request/done handshake.

An erase job can be suspended. A suspend during the collection window takes effect at once. A suspend during an active erase takes effect after a fixed latency. A resume continues the blocks still pending. A read/reset while suspended abandons the job and records the blocks left unfinished as stale. Any failing block sets a sticky error flag and records the index of the block. All durations are parameters counted in clock cycles.

Top module: `erase_sched`

## Requirements
- R1: The target block of a confirm is decoded from address bits 17..13, taken as a 5-bit segment code: codes 0-7 give block 0, 8-15 block 1, 16-23 block 2, 24-27 block 3, 28 block 4, 29 block 5, and 30-31 block 6. Bit i of `erase_map` stands for block i.
- R2: A confirm while idle or in the window sets that block's bit in `erase_map`. `timer_active` then stays high for exactly WIN_CYC cycles after the most recent confirm.
- R3: After the window, pending blocks are requested one at a time in ascending index order. Each is requested with `ers_req` high and its index on `ers_blk`. A block's bit clears on `ers_done`, and the block returns to idle when no bit is left. While erasing, `erase_map` never gains a bit.
- R4: Blocks whose `protect_mask` bit is set when the erase starts are removed from `erase_map` and are never requested.
- R5: If every selected block is protected, `busy` stays high for exactly HOLD_CYC cycles after the window with no request, and the block then returns to idle.
- R6: A chip erase while idle selects all blocks and starts at once, without a window. All unprotected blocks are erased in ascending order.
- R7: A suspend during the window sets `suspended` on the next cycle, ends `timer_active`, and issues no request.
- R8: A suspend during an erase keeps `suspended` low for SUSP_CYC cycles, then raises it. While suspended, `ers_req` is low and `busy` is low. A resume erases every block still pending.
- R9: A read/reset while suspended clears `erase_map`, ORs the abandoned blocks into `stale_map`, and returns to idle. A later successful erase of a block clears its stale bit.
- R10: An `ers_done` with `ers_fail` sets `err`. `err_blk` holds the first failing block. `err` is cleared only by a read/reset given while idle or suspended; a read/reset while busy is ignored.
- R11: Block confirms and chip erases received while an erase is running are ignored.
- R12: After reset, `busy`, `suspended`, `timer_active`, `err`, `ers_req`, `erase_map` and `stale_map` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_block_confirm | input | 1 | Block erase confirm pulse |
| cmd_chip_erase | input | 1 | Chip erase pulse |
| cmd_addr | input | 18 | Byte address of the confirm |
| cmd_suspend | input | 1 | Suspend pulse |
| cmd_resume | input | 1 | Resume pulse |
| cmd_reset | input | 1 | Read/reset pulse |
| protect_mask | input | 7 | Per-block protection |
| ers_done | input | 1 | Array finished the requested block |
| ers_fail | input | 1 | Qualifies ers_done as a failure |
| ers_req | output | 1 | Erase request to the array |
| ers_blk | output | 3 | Block being requested |
| erase_map | output | 7 | Blocks selected and not yet erased |
| stale_map | output | 7 | Blocks left invalid by an abandoned job |
| busy | output | 1 | Window, erase, suspend latency or protected hold |
| suspended | output | 1 | Job parked in suspend |
| timer_active | output | 1 | Collection window running |
| err | output | 1 | Sticky erase failure |
| err_blk | output | 3 | First failing block |

## Verification
A wrong state or a wrong counter value shows up at the ports within one cycle. Each mode has its own flag and its own window length, so `busy`, `suspended` and `timer_active` stop matching the counts the requirements call for. A fault in the pending map or in the picker shows up as a wrong request order, or as an extra or missing request, at the block's next `ers_done`. A corrupted stale or error record lasts until the next job or read/reset, and is read directly from `stale_map`, `err` and `err_blk`.

// File: rtl/erase_sched_pkg.sv
package erase_sched_pkg;

    localparam int NBLK = 7;
    localparam int BW   = $clog2(NBLK);
    localparam int AW   = 18;
    localparam int SEGW = 5;

    typedef logic [NBLK-1:0] blk_map_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WINDOW,
        ST_ERASE,
        ST_SUSP_WAIT,
        ST_SUSPENDED,
        ST_PROT_HOLD
    } sched_st_e;

    typedef struct packed {
        logic          found;
        logic [BW-1:0] idx;
    } pick_t;

    // Segment code (8 KB units) to block index, boot block at the top.
    function automatic logic [BW-1:0] seg_to_blk(input logic [SEGW-1:0] seg);
        logic [BW-1:0] b;
        if (seg < 5'd24)       b = BW'(seg >> 3);
        else if (seg < 5'd28)  b = BW'(3);
        else if (seg == 5'd28) b = BW'(4);
        else if (seg == 5'd29) b = BW'(5);
        else                   b = BW'(6);
        return b;
    endfunction

endpackage

// File: rtl/es_countdown.sv
module es_countdown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/es_lowest.sv
module es_lowest
    import erase_sched_pkg::*;
#(
    parameter int N = NBLK
) (
    input  logic [N-1:0] map,
    output pick_t        pick
);
    always_comb begin
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (map[i]) begin
                pick.found = 1'b1;
                pick.idx   = BW'(i);
            end
        end
    end
endmodule

// File: rtl/erase_sched.sv
module erase_sched
    import erase_sched_pkg::*;
#(
    parameter int WIN_CYC  = 64,
    parameter int SUSP_CYC = 16,
    parameter int HOLD_CYC = 128
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_block_confirm,
    input  logic                cmd_chip_erase,
    input  logic [AW-1:0]       cmd_addr,
    input  logic                cmd_suspend,
    input  logic                cmd_resume,
    input  logic                cmd_reset,
    input  logic [NBLK-1:0]     protect_mask,
    input  logic                ers_done,
    input  logic                ers_fail,
    output logic                ers_req,
    output logic [BW-1:0]       ers_blk,
    output logic [NBLK-1:0]     erase_map,
    output logic [NBLK-1:0]     stale_map,
    output logic                busy,
    output logic                suspended,
    output logic                timer_active,
    output logic                err,
    output logic [BW-1:0]       err_blk
);
    localparam int MAXC = (WIN_CYC > SUSP_CYC) ?
                          ((WIN_CYC > HOLD_CYC) ? WIN_CYC : HOLD_CYC) :
                          ((SUSP_CYC > HOLD_CYC) ? SUSP_CYC : HOLD_CYC);
    localparam int CW = $clog2(MAXC + 1);
    localparam logic [CW-1:0] WIN_LD  = CW'(WIN_CYC - 1);
    localparam logic [CW-1:0] SUSP_LD = CW'(SUSP_CYC - 1);
    localparam logic [CW-1:0] HOLD_LD = CW'(HOLD_CYC - 1);

    sched_st_e st_q, st_n;
    blk_map_t  pend_q, pend_n, stale_q, stale_n;
    logic      err_q, err_n;
    logic [BW-1:0] eblk_q, eblk_n;

    logic          cnt_load, cnt_zero;
    logic [CW-1:0] cnt_val;
    pick_t         pick;

    es_countdown #(.W(CW)) u_cnt (
        .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val), .zero(cnt_zero)
    );

    es_lowest #(.N(NBLK)) u_pick (.map(pend_q), .pick(pick));

    blk_map_t sel_bit, start_eff, after_done;
    logic     erasing, took_done;

    assign sel_bit   = blk_map_t'(1) << seg_to_blk(cmd_addr[AW-1 -: SEGW]);
    assign start_eff = ((st_q == ST_IDLE) ? '1 : pend_q) & ~protect_mask;
    assign erasing   = (st_q == ST_ERASE) || (st_q == ST_SUSP_WAIT);
    assign ers_req   = erasing && pick.found;
    assign ers_blk   = pick.idx;
    assign took_done = ers_req && ers_done;

    always_comb begin
        after_done = pend_q;
        stale_n    = stale_q;
        err_n      = err_q;
        eblk_n     = eblk_q;
        if (took_done) begin
            after_done[pick.idx] = 1'b0;
            if (ers_fail) begin
                err_n = 1'b1;
                if (!err_q) eblk_n = pick.idx;
            end else begin
                stale_n[pick.idx] = 1'b0;
            end
        end
        st_n     = st_q;
        pend_n   = after_done;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (st_q)
            ST_IDLE: begin
                if (cmd_chip_erase) begin
                    st_n = (start_eff == '0) ? ST_PROT_HOLD : ST_ERASE;
                    pend_n = start_eff;
                    if (start_eff == '0) begin cnt_load = 1'b1; cnt_val = HOLD_LD; end
                end else if (cmd_block_confirm) begin
                    st_n = ST_WINDOW;
                    pend_n = pend_q | sel_bit;
                    cnt_load = 1'b1; cnt_val = WIN_LD;
                end else if (cmd_reset) begin
                    err_n = 1'b0;
                end
            end
            ST_WINDOW: begin
                if (cmd_suspend) begin
                    st_n = ST_SUSPENDED;
                end else if (cmd_block_confirm) begin
                    pend_n = pend_q | sel_bit;
                    cnt_load = 1'b1; cnt_val = WIN_LD;
                end else if (cnt_zero) begin
                    st_n = (start_eff == '0) ? ST_PROT_HOLD : ST_ERASE;
                    pend_n = start_eff;
                    if (start_eff == '0) begin cnt_load = 1'b1; cnt_val = HOLD_LD; end
                end
            end
            ST_ERASE: begin
                if (after_done == '0) begin
                    st_n = ST_IDLE;
                end else if (cmd_suspend) begin
                    st_n = ST_SUSP_WAIT;
                    cnt_load = 1'b1; cnt_val = SUSP_LD;
                end
            end
            ST_SUSP_WAIT: begin
                if (after_done == '0)  st_n = ST_IDLE;
                else if (cnt_zero)     st_n = ST_SUSPENDED;
            end
            ST_SUSPENDED: begin
                if (cmd_reset) begin
                    st_n    = ST_IDLE;
                    stale_n = stale_q | pend_q;
                    pend_n  = '0;
                    err_n   = 1'b0;
                end else if (cmd_resume) begin
                    st_n = (start_eff == '0) ? ST_PROT_HOLD : ST_ERASE;
                    pend_n = start_eff;
                    if (start_eff == '0) begin cnt_load = 1'b1; cnt_val = HOLD_LD; end
                end
            end
            ST_PROT_HOLD: begin
                if (cnt_zero) st_n = ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            pend_q  <= '0;
            stale_q <= '0;
            err_q   <= 1'b0;
            eblk_q  <= '0;
        end else begin
            st_q    <= st_n;
            pend_q  <= pend_n;
            stale_q <= stale_n;
            err_q   <= err_n;
            eblk_q  <= eblk_n;
        end
    end

    assign erase_map    = pend_q;
    assign stale_map    = stale_q;
    assign busy         = (st_q != ST_IDLE) && (st_q != ST_SUSPENDED);
    assign suspended    = (st_q == ST_SUSPENDED);
    assign timer_active = (st_q == ST_WINDOW);
    assign err          = err_q;
    assign err_blk      = eblk_q;
endmodule

// File: rtl/erase_sched_chk.sv
module erase_sched_chk
    import erase_sched_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            cmd_reset,
    input logic            ers_req,
    input logic [NBLK-1:0] erase_map,
    input logic            busy,
    input logic            suspended,
    input logic            timer_active,
    input logic            err
);
    // R2
    window_no_req_chk: assert property (@(posedge clk) disable iff (rst)
        timer_active |-> !ers_req);

    // R8
    suspend_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        suspended |-> (!ers_req && !busy));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err && !cmd_reset) |=> err);

    // R3
    map_no_grow_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !timer_active) |=> ((erase_map & ~$past(erase_map)) == '0));

    // R3
    req_has_work_chk: assert property (@(posedge clk) disable iff (rst)
        ers_req |-> (erase_map != '0));

    // R7
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({suspended, timer_active}));
endmodule

bind erase_sched erase_sched_chk u_chk (
    .clk(clk), .rst(rst), .cmd_reset(cmd_reset), .ers_req(ers_req),
    .erase_map(erase_map), .busy(busy), .suspended(suspended),
    .timer_active(timer_active), .err(err)
);

// File: tb/sim_erase_sched.sv
module sim_erase_sched;
    localparam int W = 8, S = 3, H = 6, ECYC = 5;

    logic clk = 0, rst = 1;
    logic cmd_block_confirm = 0, cmd_chip_erase = 0, cmd_suspend = 0;
    logic cmd_resume = 0, cmd_reset = 0;
    logic [17:0] cmd_addr = '0;
    logic [6:0]  protect_mask = '0, fail_mask = '0;
    logic ers_done = 0, ers_fail = 0, ers_req, busy, suspended, timer_active, err;
    logic [2:0] ers_blk, err_blk;
    logic [6:0] erase_map, stale_map;

    int checks = 0, fails = 0, n_done = 0, acnt = 0;
    logic [2:0] log_q [0:255];
    bit finished = 0;

    always #2 clk = ~clk;

    erase_sched #(.WIN_CYC(W), .SUSP_CYC(S), .HOLD_CYC(H)) u0 (
        .clk(clk), .rst(rst), .cmd_block_confirm(cmd_block_confirm),
        .cmd_chip_erase(cmd_chip_erase), .cmd_addr(cmd_addr),
        .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume), .cmd_reset(cmd_reset),
        .protect_mask(protect_mask), .ers_done(ers_done), .ers_fail(ers_fail),
        .ers_req(ers_req), .ers_blk(ers_blk), .erase_map(erase_map),
        .stale_map(stale_map), .busy(busy), .suspended(suspended),
        .timer_active(timer_active), .err(err), .err_blk(err_blk)
    );

    // Array model: finishes a block ECYC cycles after its request.
    always @(posedge clk) begin
        ers_done <= 1'b0;
        if (rst) acnt <= 0;
        else if (ers_req && !ers_done) begin
            if (acnt == ECYC - 1) begin
                ers_done <= 1'b1;
                ers_fail <= fail_mask[ers_blk];
                log_q[n_done[7:0]] <= ers_blk;
                n_done <= n_done + 1;
                acnt <= 0;
            end else acnt <= acnt + 1;
        end else if (!ers_req) acnt <= 0;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic confirm(input logic [4:0] seg);
        cmd_addr = {seg, 13'h0}; cmd_block_confirm = 1; tick(); cmd_block_confirm = 0;
    endtask
    task automatic chip();   cmd_chip_erase = 1; tick(); cmd_chip_erase = 0; endtask
    task automatic susp();   cmd_suspend = 1;    tick(); cmd_suspend = 0;    endtask
    task automatic resume(); cmd_resume = 1;     tick(); cmd_resume = 0;     endtask
    task automatic rdrst();  cmd_reset = 1;      tick(); cmd_reset = 0;      endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000 && (busy || timer_active); i++) tick();
    endtask

    function automatic int exp_blk(input int seg);
        if (seg < 24) return seg / 8;
        if (seg < 28) return 3;
        if (seg == 28) return 4;
        if (seg == 29) return 5;
        return 6;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int base, n;
        logic [6:0] m;
        tick(3); rst = 0; tick();
        // R12 reset state
        chk("R12 busy", busy, 0); chk("R12 susp", suspended, 0);
        chk("R12 timer", timer_active, 0); chk("R12 err", err, 0);
        chk("R12 req", ers_req, 0); chk("R12 map", erase_map, 0);
        chk("R12 stale", stale_map, 0);

        // R1 sweep over all segment codes; R7 suspend in window; R9 abandon
        for (int seg = 0; seg < 32; seg++) begin
            confirm(5'(seg));
            chk("R1 decode", erase_map, 1 << exp_blk(seg));
            susp();
            chk("R7 suspended", suspended, 1);
            chk("R7 timer off", timer_active, 0);
            rdrst();
            chk("R9 abandon map", erase_map, 0);
        end
        chk("R9 stale set", stale_map, 7'h7f);

        // R6 chip erase, no window, ascending order; R9 stale cleared
        base = n_done;
        chip();
        chk("R6 no window", timer_active, 0);
        chk("R6 all selected", erase_map, 7'h7f);
        wait_idle();
        chk("R6 count", n_done - base, 7);
        for (int i = 0; i < 7; i++) chk("R6 order", log_q[base + i], i);
        chk("R9 stale cleared", stale_map, 0);

        // R2 window length, restart on further confirm; R3 order
        base = n_done;
        confirm(5'd30); tick(3); confirm(5'd28); tick(2); confirm(5'd0);
        chk("R2 accumulate", erase_map, 7'b1010001);
        n = 0;
        while (timer_active && n < 100) begin n++; tick(); end
        chk("R2 window length", n, W);
        wait_idle();
        chk("R3 count", n_done - base, 3);
        chk("R3 first", log_q[base], 0); chk("R3 second", log_q[base + 1], 4);
        chk("R3 third", log_q[base + 2], 6);
        chk("R3 empty", erase_map, 0);

        // R4 protected block skipped
        base = n_done; protect_mask = 7'b0010000;
        confirm(5'd28); confirm(5'd8);
        while (timer_active) tick();
        chk("R4 masked map", erase_map, 7'b0000010);
        wait_idle();
        chk("R4 count", n_done - base, 1);
        chk("R4 block", log_q[base], 1);

        // R5 all protected
        base = n_done; protect_mask = 7'b0000100;
        confirm(5'd16);
        while (timer_active) tick();
        n = 0;
        while (busy && n < 100) begin
            if (ers_req) n = 1000;
            n++; tick();
        end
        chk("R5 hold length", n, H);
        chk("R5 no erase", n_done - base, 0);
        protect_mask = '0;

        // R11 confirm while erasing ignored
        base = n_done;
        confirm(5'd0);
        while (timer_active) tick();
        confirm(5'd29);
        chk("R11 confirm ignored", erase_map[5], 0);
        chip();
        chk("R11 chip ignored", erase_map[6], 0);
        wait_idle();
        chk("R11 count", n_done - base, 1);

        // R8 suspend during erase, resume
        base = n_done;
        chip();
        while (n_done - base < 2) tick();
        susp();
        n = 0;
        while (!suspended && n < 100) begin n++; tick(); end
        chk("R8 latency", n, S);
        tick(4);
        chk("R8 no req", ers_req, 0);
        chk("R8 not busy", busy, 0);
        m = erase_map;
        chk("R8 pending kept", m != 0, 1);
        resume();
        wait_idle();
        chk("R8 all erased", n_done - base, 7);
        chk("R8 map empty", erase_map, 0);

        // R10 error sticky, reset while busy ignored, first failing block
        base = n_done; fail_mask = 7'b0101000;
        chip();
        while (!err && busy) tick();
        rdrst();
        chk("R10 reset ignored err", err, 1);
        chk("R10 reset ignored busy", busy, 1);
        wait_idle();
        chk("R10 err", err, 1);
        chk("R10 err_blk", err_blk, 3);
        rdrst();
        chk("R10 cleared", err, 0);
        fail_mask = '0;

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule